// File: doc/BRIEF.md
# Marker-Bit UART Transmitter

This block serialises one byte at a time onto an asynchronous serial line. The frame is a low start bit, eight data bits with the least significant bit first, and a high stop bit. A one-cycle write strobe hands over a byte. Bit timing comes from an external free-running divide-by-16 counter that runs at sixteen times the baud rate. That counter's rollover reaches the block as a one-cycle `tick` pulse, and every bit edge of the frame sits on such a tick, never on the write strobe itself.

End of frame is found without a bit counter. The byte is loaded into a nine-bit shift register with a 1 above it. Zeros enter from the top on every shift. When only that marker 1 is left, directly above the last data bit, the control makes one final shift, leaves the send phase and raises a sticky done flag. Software clears that flag with a separate strobe.

Top module: `marker_uart_tx`

## Requirements
- R1: While reset is asserted and after it is released, `txd` is 1 and `done` is 0 until a frame is requested.
- R2: A frame on `txd` is one bit time of 0, then `wr_data[0]` through `wr_data[7]` in that order, one bit time each, then 1.
- R3: The start bit begins at the first tick after the cycle that carried the write, and it does not begin at a tick in that same cycle. `txd` changes only in the cycle after a tick, so each bit lasts exactly one tick period.
- R4: A single frame takes ten ticks to complete. The k-th tick after the write (k = 1..9) puts frame bit k on the line: start bit first, then data bits in order.
- R5: `done` rises at the tenth tick after the write, in the same cycle that `txd` returns to 1 for the stop bit.
- R6: A write while a frame is pending or being sent is ignored. This holds up to and including the tick-10 cycle, and the frame in flight goes out unchanged.
- R7: `done` stays 1 until `done_clr` is pulsed, after which it reads 0. If the clear arrives in the same cycle as the tick that sets the flag, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse at each rollover of the divide-by-16 counter |
| wr_en | input | 1 | Write strobe requesting a transmission |
| wr_data | input | DATA_W | Byte to send |
| done_clr | input | 1 | Clears the done flag |
| txd | output | 1 | Serial output, idles high |
| done | output | 1 | Sticky frame-complete flag |

## Verification
The assertions assume that `tick` is a single-cycle pulse spaced by more than one clock. They also assume that `wr_en` is sampled only on clock edges, so a write can land anywhere in the tick period, including on the tick cycle itself. The bench keeps to this by driving `tick` every sixteen clocks and driving all inputs half a cycle away from the active edge. It sweeps every byte value and steps the write across all sixteen phases of the tick period. It also injects stray writes only while a frame is busy, and pulses the clear strobe either on the setting tick or after the frame has completed.

// File: rtl/marker_uart_tx.sv
module marker_uart_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              done_clr,
  output logic              txd,
  output logic              done
);
  localparam int SR_W = DATA_W + 1;

  logic [SR_W-1:0] shreg;
  logic            pending;
  logic            send_ph;
  logic            data_ph;

  wire busy       = pending | send_ph;
  wire shift_en   = tick & send_ph & data_ph;
  wire last_shift = (shreg[SR_W-1:2] == '0) & shreg[1];
  wire finish     = shift_en & last_shift;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg   <= '0;
      pending <= 1'b0;
      send_ph <= 1'b0;
      data_ph <= 1'b0;
    end else begin
      if (wr_en && !busy) begin
        shreg   <= {1'b1, wr_data};
        pending <= 1'b1;
      end
      if (tick && pending) begin
        pending <= 1'b0;
        send_ph <= 1'b1;
      end
      if (tick && send_ph && !data_ph)
        data_ph <= 1'b1;
      if (shift_en) begin
        shreg <= {1'b0, shreg[SR_W-1:1]};
        if (last_shift) begin
          send_ph <= 1'b0;
          data_ph <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      done <= 1'b0;
    else if (finish)
      done <= 1'b1;
    else if (done_clr)
      done <= 1'b0;
  end

  assign txd = ~send_ph | (data_ph & shreg[0]);

  assert_done_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(tick));

  assert_txd_edge_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(txd) |-> $past(tick));

  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(send_ph) |-> !txd);

  assert_busy_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && !tick) |=> ($stable(shreg) && $stable(pending) && $stable(send_ph)));

  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_clr) |=> done);

endmodule

// File: tb/test_marker_uart_tx.sv
`timescale 1ns/1ps
module test_marker_uart_tx;
  logic       clk = 1'b0;
  logic       rst_n, tick, wr_en, done_clr;
  logic [7:0] wr_data;
  logic       txd, done;

  int checks = 0;
  int fails  = 0;
  int ticks_seen = 0;
  int tcnt = 0;

  always #2.5 clk = ~clk;

  marker_uart_tx #(.DATA_W(8)) i_marker_uart_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
    .done_clr(done_clr), .txd(txd), .done(done)
  );

  initial tick = 1'b0;
  always @(negedge clk) begin
    tcnt <= (tcnt == 15) ? 0 : tcnt + 1;
    tick <= (tcnt == 14);
  end

  always @(posedge clk) if (tick) ticks_seen <= ticks_seen + 1;

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic run_frame(input logic [7:0] d, input int lead, input bit inject, input bit clr_on_tick);
    int base;
    int n;
    int exp_txd;
    repeat (lead) step();
    wr_en = 1'b1; wr_data = d;
    step();
    wr_en = 1'b0;
    base = ticks_seen;
    forever begin
      n = ticks_seen - base;
      if (n == 0) exp_txd = 1;
      else if (n == 1) exp_txd = 0;
      else if (n <= 9) exp_txd = int'(d[n-2]);
      else exp_txd = 1;
      chk((n <= 1) ? "R3 txd" : (n <= 9 ? "R2/R4 txd" : "R2 stop"), int'(txd), exp_txd);
      chk((n >= 10) ? "R5 done set" : "R5 done early", int'(done), (n >= 10) ? 1 : 0);
      if (n >= 11) break;
      wr_en   = inject && (n == 0 || n == 5 || n == 9);
      wr_data = ~d;
      done_clr = clr_on_tick && (n == 9) && tick;
      step();
    end
    wr_en = 1'b0; done_clr = 1'b0;
    repeat (3) step();
    chk("R7 sticky", int'(done), 1);
    chk("R6 idle after frame", int'(txd), 1);
    done_clr = 1'b1;
    step();
    done_clr = 1'b0;
    chk("R7 cleared", int'(done), 0);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = 8'h00; done_clr = 1'b0;
    repeat (4) step();
    chk("R1 txd in reset", int'(txd), 1);
    chk("R1 done in reset", int'(done), 0);
    rst_n = 1'b1;
    repeat (3) step();
    chk("R1 txd after reset", int'(txd), 1);
    chk("R1 done after reset", int'(done), 0);
    for (int i = 0; i < 256; i++)
      run_frame(i[7:0], (i * 7) % 16, (i % 3) == 1, (i % 5) == 2);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule